// File: doc/BRIEF.md
# Crystal-Tick Halt and Wake Controller

This block governs the low-power pause of a small 4-bit controller core. A binary prescaler counts ticks from a 32.768 kHz watch crystal and fires an overflow once every 2048 ticks, which is 16 Hz. When the core executes its latch-clearing instruction, it pulses `halt_req`. This clears a wake latch and parks the core in internal halt. The next natural overflow sets the latch again, ends the halt and adds one to a small timer register. The program counter then moves on to the instruction after the halting one.

A separate pin, `ext_halt`, stops the core for as long as it is high. Prescaler overflows cannot release that halt. While either halt source is active, `pc_advance` is low and the core issues nothing. The two crystal pins are reserved for the oscillator. Here they appear only as the qualified `xtal_tick` enable and are never read as general inputs.

Top module: `halt_wake_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the prescaler and the timer, sets the wake latch, and leaves `int_halt`=0, `halted`=0, `pc_advance`=1 and `timer_val`=0 after the edge.
- R2: The prescaler advances only on cycles with `xtal_tick`=1 and overflows on the tick that takes its count from 2047 back to 0, once per 2048 ticks.
- R3: `halt_req` while `halted`=0 clears the wake latch at that edge, so `int_halt`=1 and `pc_advance`=0 from the next cycle.
- R4: An overflow while `int_halt`=1 and `ext_halt`=0 sets the wake latch at that edge, so `int_halt`=0 and `pc_advance`=1 from the next cycle.
- R5: Each overflow-driven wake adds exactly 1 to the 4-bit `timer_val`, wrapping from 15 to 0. The timer changes at no other time except reset.
- R6: While `ext_halt`=1, `pc_advance` is 0 in the same cycle, and overflows neither release internal halt nor change the timer.
- R7: Once `ext_halt` returns to 0, `pc_advance` goes back to 1 in that cycle unless internal halt is active, in which case the next overflow releases it.
- R8: Entering halt does not restart the prescaler, so the wake comes on the next 2048-tick boundary counted from reset.
- R9: `halt_req` has no effect while `halted`=1, from either source.
- R10: If `halt_req` arrives while running in the same cycle as an overflow, halt is entered and lasts until the following overflow, 2048 ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| xtal_tick | input | 1 | One-cycle enable per crystal period |
| halt_req | input | 1 | Strobe from the latch-clearing instruction |
| ext_halt | input | 1 | External halt pin, active high |
| int_halt | output | 1 | Wake latch is cleared (internal halt) |
| halted | output | 1 | Either halt source active |
| pc_advance | output | 1 | 1 lets the program counter step and instructions issue |
| timer_val | output | 4 | Timer register, counts wakes |

## Verification
The bench runs seventeen consecutive halt/wake rounds on the full 2048-tick divider. This covers the timer wrap from 15 to 0, where a design without the wrap, or one that bumps the timer on every overflow, would give a wrong count. Halt requests are placed at odd points in the prescaler cycle and under sparse ticks. A design that restarts the prescaler on halt entry, or counts clock cycles instead of ticks, would then wake on the wrong cycle. `ext_halt` is held across an overflow during internal halt, and `halt_req` is pulsed under it. A design that lets the overflow win, or latches the masked request, would resume too early or stay stuck. A request that coincides exactly with an overflow catches a design that lets the overflow cancel the new halt.

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl #(
  parameter int DIV_W = 11,
  parameter int TMR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xtal_tick,
  input  logic             halt_req,
  input  logic             ext_halt,
  output logic             int_halt,
  output logic             halted,
  output logic             pc_advance,
  output logic [TMR_W-1:0] timer_val
);

  logic [DIV_W-1:0] presc_q;
  logic [TMR_W-1:0] timer_q;
  logic             wake_q;
  logic             ovf, enter, wake;

  assign ovf   = xtal_tick & (&presc_q);
  assign enter = wake_q & ~ext_halt & halt_req;
  assign wake  = ~wake_q & ~ext_halt & ovf;

  always_ff @(posedge clk) begin
    if (rst)            presc_q <= '0;
    else if (xtal_tick) presc_q <= presc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_q  <= 1'b1;
      timer_q <= '0;
    end else if (enter) begin
      wake_q  <= 1'b0;
    end else if (wake) begin
      wake_q  <= 1'b1;
      timer_q <= timer_q + 1'b1;
    end
  end

  assign int_halt   = ~wake_q;
  assign halted     = ext_halt | ~wake_q;
  assign pc_advance = ~halted;
  assign timer_val  = timer_q;

  // R3
  enter_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && halt_req) |=> int_halt);

  // R4
  ovf_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (int_halt && !ext_halt && ovf) |=> !int_halt);

  // R5
  timer_step_chk: assert property (@(posedge clk) disable iff (rst)
    (int_halt && !ext_halt && ovf) |=> timer_val == TMR_W'($past(timer_val) + 1'b1));

  // R6
  ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_halt && int_halt) |=> (int_halt && $stable(timer_val)));

  // R9
  req_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_halt && !int_halt) |=> !int_halt);

  // R6
  ext_pc_chk: assert property (@(posedge clk) ext_halt |-> !pc_advance);

endmodule

// File: tb/sim_halt_wake_ctrl.sv
module sim_halt_wake_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1, tick = 1'b0, req = 1'b0, hlt = 1'b0;
  logic int_halt, halted, pc_advance;
  logic [3:0] timer_val;

  int checks = 0, failures = 0;
  int m_cnt = 0, m_tmr = 0;
  bit m_latch = 1'b1;
  string phase = "R1";

  always #10 clk = ~clk;

  halt_wake_ctrl u0 (
    .clk(clk), .rst(rst), .xtal_tick(tick), .halt_req(req), .ext_halt(hlt),
    .int_halt(int_halt), .halted(halted), .pc_advance(pc_advance), .timer_val(timer_val)
  );

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit t, input bit r, input bit h, input bit rs = 1'b0);
    bit ovf;
    @(negedge clk);
    tick = t; req = r; hlt = h; rst = rs;
    @(posedge clk);
    if (rs) begin
      m_cnt = 0; m_latch = 1'b1; m_tmr = 0;
    end else begin
      ovf = t && (m_cnt == 2047);
      if (t) m_cnt = (m_cnt + 1) % 2048;
      if (!h && m_latch && r) m_latch = 1'b0;
      else if (!h && !m_latch && ovf) begin
        m_latch = 1'b1;
        m_tmr = (m_tmr + 1) % 16;
      end
    end
    #2;
    chk({phase, " int_halt"}, int_halt, !m_latch);
    chk({phase, " halted"}, halted, h || !m_latch);
    chk({phase, " pc_advance"}, pc_advance, !(h || !m_latch));
    chk({phase, " timer"}, timer_val, m_tmr);
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int waited;
    cyc(0, 0, 0, 1);
    phase = "R1";
    chk("R1 reset pc_advance", pc_advance, 1);
    chk("R1 reset timer", timer_val, 0);

    phase = "R2";
    for (int i = 0; i < 301; i++) cyc(i % 3 == 0, 0, 0);

    for (int k = 0; k < 17; k++) begin
      phase = "R3";
      cyc(1, 1, 0);
      chk("R3 halt entered", int_halt, 1);
      waited = 2048 - m_cnt;
      phase = "R8";
      for (int i = 0; i < waited - 1; i++) cyc(1, 0, 0);
      chk("R8 still halted before boundary", int_halt, 1);
      phase = "R4";
      cyc(1, 0, 0);
      chk("R4 woke on boundary", pc_advance, 1);
      chk("R5 timer count", timer_val, (k + 1) % 16);
      phase = "R2";
      for (int i = 0; i < 37 * (k + 1); i++) cyc(i % 2 == 0, 0, 0);
    end

    phase = "R6";
    cyc(1, 1, 0);
    for (int i = 0; i < 2100; i++) cyc(1, 0, 1);
    chk("R6 ext halt held internal halt", int_halt, 1);
    phase = "R7";
    cyc(1, 0, 0);
    chk("R7 still internally halted", int_halt, 1);
    while (m_cnt != 0) cyc(1, 0, 0);
    chk("R7 released at next overflow", pc_advance, 1);

    phase = "R9";
    for (int i = 0; i < 20; i++) cyc(1, i % 4 == 1, 1);
    cyc(1, 0, 0);
    chk("R9 masked request ignored", pc_advance, 1);
    cyc(1, 1, 0);
    for (int i = 0; i < 10; i++) cyc(1, 1, 0);
    chk("R9 request while halted", int_halt, 1);
    while (m_latch == 0) cyc(1, 0, 0);

    phase = "R10";
    while (m_cnt != 2047) cyc(1, 0, 0);
    cyc(1, 1, 0);
    chk("R10 halt wins over overflow", int_halt, 1);
    for (int i = 0; i < 2047; i++) cyc(1, 0, 0);
    chk("R10 halted until next overflow", int_halt, 1);
    cyc(1, 0, 0);
    chk("R10 woke after full period", int_halt, 0);

    phase = "R1";
    cyc(1, 1, 0);
    cyc(1, 0, 0, 1);
    chk("R1 reset clears halt", pc_advance, 1);
    chk("R1 reset clears timer", timer_val, 0);
    phase = "R8";
    for (int i = 0; i < 500; i++) cyc(1, 0, 0);
    cyc(1, 1, 0);
    while (m_latch == 0) cyc(1, 0, 0);
    chk("R8 prescaler restarted by reset only", timer_val, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule